// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Bank

This block holds the software-visible control registers of a dual-channel bus-master disk DMA controller. Each channel has an 8-byte bank. The second bank sits 8 bytes above the first, so the whole window is 16 bytes. A bank contains four parts:
- a command byte that starts or stops the channel and selects the transfer direction;
- a status byte whose bits follow three different write policies;
- an optional mode byte and an optional per-channel timing byte;
- a 32-bit, dword-aligned descriptor-table pointer.

The bus side is a single-cycle register port. Each access has an address, a size code and right-justified data. Reads are combinational and have no side effects. Writes take effect at the clock edge.

On the engine side, the bank sends one-cycle start, cancel and pointer-load strobes to the DMA engine. It receives three per-channel inputs from the engine: done, error and interrupt. Descriptor fetch and data movement are handled outside this block.

Top module: `bmdma_regbank`

## Requirements
- R1: The command byte sits at bank offset 0. It keeps only bit 0 (run) and bit 3 (direction). Every other bit reads back as 0. Bit 3 drives `dma_dir_o`. Offsets 0 to 3 always return a byte, zero-extended to 32 bits, whatever the access size.
- R2: A command write with bit 0 clear makes `dma_cancel_o` pulse for the cycle after the write edge. It also clears status bit 0 (active). Start and cancel are never high together.
- R3: A command write with bit 0 set, while status bit 0 is 0, sets the active bit and pulses `dma_start_o` for the cycle after the write edge. If active is already 1, no start pulse is produced.
- R4: The status byte sits at offset 2. Bits 5 and 6 take the written value. Bit 0 ignores writes. Bits 1 (error) and 2 (interrupt) clear when a 1 is written to them. Bits 3, 4 and 7 read as 0.
- R5: A high `eng_err_i` sets status bit 1 and a high `eng_irq_i` sets bit 2. If a set and a write-1-to-clear happen in the same cycle, the set wins. `eng_done_i` clears bit 0.
- R6: With `TIMING_EN`=1:
  - offset 1 reads a single mode byte shared by all channels; only bits 5:4 of it are writable;
  - offset 3 reads a per-channel timing byte that is fully writable.

  With `TIMING_EN`=0, both offsets read 0xFF and writes to them are ignored.
- R7: Offsets 4 to 7 hold the pointer, with offset 4+k addressing byte lane k. Size codes are 0 = byte, 1 = word, 2 or 3 = dword.
  - A byte write replaces lane k.
  - A word write replaces lanes k and k+1; lanes above 3 are dropped.
  - A dword write replaces the whole pointer.
  - Bits 1:0 are always stored as 0.
  - Byte and word reads return the value shifted right by 8k and masked to 8 or 16 bits. Dword reads return the whole pointer.
- R8: Any pointer write pulses `cur_load_o` for that channel in the cycle after the write edge. In that same cycle, `cur_addr_o` shows the new pointer.
- R9: Channel c's bank is at byte address 8c. A write to one channel leaves the other channel's registers and strobes unchanged.
- R10: Reset clears command, status, pointer, timing and mode to 0, and holds all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write enable for the current access |
| bus_addr_i | input | WIN_AW (4) | Byte address in the 16-byte window |
| bus_size_i | input | 2 | Access size: 0 byte, 1 word, 2/3 dword |
| bus_wdata_i | input | 32 | Write data, right-justified |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, right-justified |
| eng_done_i | input | NUM_CH | Engine finished; clears active |
| eng_err_i | input | NUM_CH | Engine error; sets status bit 1 |
| eng_irq_i | input | NUM_CH | Engine interrupt; sets status bit 2 |
| dma_start_o | output | NUM_CH | One-cycle start strobe |
| dma_cancel_o | output | NUM_CH | One-cycle cancel strobe |
| dma_dir_o | output | NUM_CH | Command direction bit |
| cur_load_o | output | NUM_CH | One-cycle current-pointer load strobe |
| cur_addr_o | output | NUM_CH*32 | Descriptor pointer, channel c at bits 32c+31:32c |

## Verification
The bench targets the following corner cases, each with the symptom a faulty design would show:
- Sub-word pointer writes, including a word write at lane 3. A design that merged lanes wrongly would corrupt bytes next to the addressed ones, or would wrap the upper byte into lane 0.
- A status write that tries to change the active bit. A design without the mixed status policies would lose the active flag when software writes 0.
- Error bits that never clear on a written 1.
- An error set and a clear of that bit in the same cycle. A design that gave the clear priority would lose an engine error.
- A second start issued while the channel is already active. A design that did not gate the strobe would restart the engine in the middle of a transfer.

## Additional checks
The bench also confirms the 0xFF readback of a build without the timing feature, and that a write to one channel does not disturb the other.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  localparam int unsigned BANK_BYTES = 8;
  localparam int unsigned DESC_LANES = 4;
  localparam int unsigned DESC_W     = DESC_LANES * 8;

  // bank offsets (decoded by software, so positions are fixed)
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_MODE = 3'd1;
  localparam logic [2:0] OFS_STAT = 3'd2;
  localparam logic [2:0] OFS_TIME = 3'd3;

  localparam logic [7:0] CMD_KEEP  = 8'h09;
  localparam logic [7:0] MODE_KEEP = 8'h30;
  localparam logic [7:0] STAT_RW   = 8'h60;
  localparam logic [7:0] STAT_W1C  = 8'h06;
  localparam logic [7:0] STAT_RO   = 8'h01;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_IRQ = 2;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } acc_size_e;

  function automatic logic [DESC_LANES-1:0] lane_mask(acc_size_e sz, logic [1:0] lane);
    case (sz)
      SZ_BYTE: return 4'b0001 << lane;
      SZ_WORD: return 4'b0011 << lane;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DESC_W-1:0] desc_merge(logic [DESC_W-1:0] old,
                                                   logic [DESC_W-1:0] wd,
                                                   acc_size_e sz,
                                                   logic [1:0] lane);
    logic [DESC_LANES-1:0] m;
    logic [DESC_W-1:0]     sh;
    logic [DESC_W-1:0]     res;
    m  = lane_mask(sz, lane);
    sh = (sz == SZ_BYTE || sz == SZ_WORD) ? (wd << {lane, 3'b000}) : wd;
    for (int i = 0; i < int'(DESC_LANES); i++) begin
      res[i*8 +: 8] = m[i] ? sh[i*8 +: 8] : old[i*8 +: 8];
    end
    res[1:0] = 2'b00;
    return res;
  endfunction

  function automatic logic [DESC_W-1:0] desc_read(logic [DESC_W-1:0] val,
                                                  acc_size_e sz,
                                                  logic [1:0] lane);
    case (sz)
      SZ_BYTE: return (val >> {lane, 3'b000}) & 32'h0000_00FF;
      SZ_WORD: return (val >> {lane, 3'b000}) & 32'h0000_FFFF;
      default: return val;
    endcase
  endfunction

  function automatic logic [7:0] stat_write(logic [7:0] old, logic [7:0] w);
    return (w & STAT_RW) | (old & STAT_RO) | (old & ~w & STAT_W1C);
  endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned WIN_AW = CH_W + 3
) (
  input  logic [WIN_AW-1:0] addr_i,
  input  logic              wr_i,
  output logic [CH_W-1:0]   ch_o,
  output logic [2:0]        ofs_o,
  output logic              hit_o,
  output logic [NUM_CH-1:0] ch_wr_o,
  output logic              mode_wr_o
);

  assign ch_o  = addr_i[WIN_AW-1:3];
  assign ofs_o = addr_i[2:0];
  assign hit_o = (int'(ch_o) < int'(NUM_CH));

  always_comb begin
    ch_wr_o = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      ch_wr_o[c] = wr_i && hit_o && (int'(ch_o) == c);
    end
  end

  assign mode_wr_o = wr_i && hit_o && (ofs_o == OFS_MODE);

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter bit TIMING_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [2:0]        ofs_i,
  input  acc_size_e         size_i,
  input  logic [DESC_W-1:0] wdata_i,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              eng_irq_i,
  output logic [7:0]        cmd_o,
  output logic [7:0]        stat_o,
  output logic [7:0]        time_o,
  output logic [DESC_W-1:0] desc_o,
  output logic              start_o,
  output logic              cancel_o,
  output logic              load_o
);

  logic [7:0]        cmd_q, stat_q, time_q, stat_n;
  logic [DESC_W-1:0] desc_q;
  logic [7:0]        wbyte;
  logic              cmd_wr, stat_wr, time_wr, desc_wr;
  logic              start_go, stop_go, act_n;

  // named events for the checks below
  assign wbyte    = wdata_i[7:0];
  assign cmd_wr   = wr_i && (ofs_i == OFS_CMD);
  assign stat_wr  = wr_i && (ofs_i == OFS_STAT);
  assign time_wr  = wr_i && (ofs_i == OFS_TIME) && TIMING_EN;
  assign desc_wr  = wr_i && ofs_i[2];
  assign start_go = cmd_wr && wbyte[0] && !stat_q[ST_ACT];
  assign stop_go  = cmd_wr && !wbyte[0];

  always_comb begin
    stat_n = stat_wr ? stat_write(stat_q, wbyte) : stat_q;
    if (eng_err_i) stat_n[ST_ERR] = 1'b1;
    if (eng_irq_i) stat_n[ST_IRQ] = 1'b1;
    if (start_go)        act_n = 1'b1;
    else if (stop_go)    act_n = 1'b0;
    else if (eng_done_i) act_n = 1'b0;
    else                 act_n = stat_q[ST_ACT];
    stat_n[ST_ACT] = act_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      stat_q   <= '0;
      time_q   <= '0;
      desc_q   <= '0;
      start_o  <= 1'b0;
      cancel_o <= 1'b0;
      load_o   <= 1'b0;
    end else begin
      if (cmd_wr)  cmd_q  <= wbyte & CMD_KEEP;
      if (time_wr) time_q <= wbyte;
      if (desc_wr) desc_q <= desc_merge(desc_q, wdata_i, size_i, ofs_i[1:0]);
      stat_q   <= stat_n;
      start_o  <= start_go;
      cancel_o <= stop_go;
      load_o   <= desc_wr;
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
  assign time_o = time_q;
  assign desc_o = desc_q;

  AST_CANCEL_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wdata_i[0]) |=> (cancel_o && !stat_q[ST_ACT])); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && cancel_o)); // R2
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (stat_q[ST_ACT] && !$past(stat_q[ST_ACT]))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata_i[0] && stat_q[ST_ACT]) |=> !start_o); // R3
  AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wdata_i[1] && !eng_err_i) |=> !stat_q[ST_ERR]); // R4
  AST_STAT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[7] == 1'b0) && (stat_q[4:3] == 2'b00)); // R4
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err_i |=> stat_q[ST_ERR]); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done_i && stat_q[ST_ACT]) |=> !stat_q[ST_ACT]); // R5
  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_o[1:0] == 2'b00); // R7
  AST_LOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |=> load_o); // R8

endmodule

// File: rtl/bmdma_mode.sv
module bmdma_mode
  import bmdma_pkg::*;
#(
  parameter bit TIMING_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  output logic [7:0] mode_o
);

  logic [7:0] mode_q;
  logic       mode_we;

  assign mode_we = wr_i && TIMING_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= (mode_q & ~MODE_KEEP) | (wbyte_i & MODE_KEEP);
  end

  assign mode_o = mode_q;

  AST_MODE_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~MODE_KEEP) == 8'h00); // R6

endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter bit          TIMING_EN = 1'b1,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic [CH_W-1:0]               ch_i,
  input  logic [2:0]                    ofs_i,
  input  logic                          hit_i,
  input  acc_size_e                     size_i,
  input  logic [NUM_CH-1:0][7:0]        cmd_i,
  input  logic [NUM_CH-1:0][7:0]        stat_i,
  input  logic [NUM_CH-1:0][7:0]        time_i,
  input  logic [NUM_CH-1:0][DESC_W-1:0] desc_i,
  input  logic [7:0]                    mode_i,
  output logic [DESC_W-1:0]             rdata_o
);

  logic [7:0] byte_v;

  always_comb begin
    byte_v  = 8'h00;
    rdata_o = '0;
    if (hit_i) begin
      case (ofs_i)
        OFS_CMD:  byte_v = cmd_i[ch_i];
        OFS_MODE: byte_v = TIMING_EN ? mode_i : 8'hFF;
        OFS_STAT: byte_v = stat_i[ch_i];
        OFS_TIME: byte_v = TIMING_EN ? time_i[ch_i] : 8'hFF;
        default:  byte_v = 8'h00;
      endcase
      if (ofs_i[2]) rdata_o = desc_read(desc_i[ch_i], size_i, ofs_i[1:0]);
      else          rdata_o = {{(DESC_W-8){1'b0}}, byte_v};
    end
  end

endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
  import bmdma_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter bit          TIMING_EN = 1'b1,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned WIN_AW = CH_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr_i,
  input  logic [WIN_AW-1:0]        bus_addr_i,
  input  logic [1:0]               bus_size_i,
  input  logic [DESC_W-1:0]        bus_wdata_i,
  output logic [DESC_W-1:0]        bus_rdata_o,
  input  logic [NUM_CH-1:0]        eng_done_i,
  input  logic [NUM_CH-1:0]        eng_err_i,
  input  logic [NUM_CH-1:0]        eng_irq_i,
  output logic [NUM_CH-1:0]        dma_start_o,
  output logic [NUM_CH-1:0]        dma_cancel_o,
  output logic [NUM_CH-1:0]        dma_dir_o,
  output logic [NUM_CH-1:0]        cur_load_o,
  output logic [NUM_CH*DESC_W-1:0] cur_addr_o
);

  acc_size_e                     size_e;
  logic [CH_W-1:0]               ch;
  logic [2:0]                    ofs;
  logic                          hit, mode_wr;
  logic [NUM_CH-1:0]             ch_wr;
  logic [NUM_CH-1:0][7:0]        cmd_a, stat_a, time_a;
  logic [NUM_CH-1:0][DESC_W-1:0] desc_a;
  logic [7:0]                    mode_v;

  assign size_e = acc_size_e'(bus_size_i);

  bmdma_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .ch_o     (ch),
    .ofs_o    (ofs),
    .hit_o    (hit),
    .ch_wr_o  (ch_wr),
    .mode_wr_o(mode_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmdma_chan #(.TIMING_EN(TIMING_EN)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (ch_wr[c]),
      .ofs_i     (ofs),
      .size_i    (size_e),
      .wdata_i   (bus_wdata_i),
      .eng_done_i(eng_done_i[c]),
      .eng_err_i (eng_err_i[c]),
      .eng_irq_i (eng_irq_i[c]),
      .cmd_o     (cmd_a[c]),
      .stat_o    (stat_a[c]),
      .time_o    (time_a[c]),
      .desc_o    (desc_a[c]),
      .start_o   (dma_start_o[c]),
      .cancel_o  (dma_cancel_o[c]),
      .load_o    (cur_load_o[c])
    );
    assign dma_dir_o[c]                     = cmd_a[c][3];
    assign cur_addr_o[c*DESC_W +: DESC_W]   = desc_a[c];
  end

  bmdma_mode #(.TIMING_EN(TIMING_EN)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mode_wr),
    .wbyte_i(bus_wdata_i[7:0]),
    .mode_o (mode_v)
  );

  bmdma_rdmux #(.NUM_CH(NUM_CH), .TIMING_EN(TIMING_EN)) u_rd (
    .ch_i   (ch),
    .ofs_i  (ofs),
    .hit_i  (hit),
    .size_i (size_e),
    .cmd_i  (cmd_a),
    .stat_i (stat_a),
    .time_i (time_a),
    .desc_i (desc_a),
    .mode_i (mode_v),
    .rdata_o(bus_rdata_o)
  );

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr)); // R9
  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_wr == '0) |=> ((dma_start_o == '0) && (dma_cancel_o == '0) && (cur_load_o == '0))); // R9

endmodule

// File: tb/bmdma_regbank_tb.sv
module bmdma_regbank_tb_top;

  localparam int NUM_CH = 2;
  localparam int AW     = 4;
  localparam int WD_CYC = 200000;

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic [1:0]  sz;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'h4, 2'd0, 32'h0000007B, 32'h0, 4'd7},       // R7 lane0, low bits dropped
    '{1'b0, 4'h4, 2'd0, 32'h0, 32'h00000078, 4'd7},
    '{1'b1, 4'h5, 2'd0, 32'h000000A5, 32'h0, 4'd7},
    '{1'b0, 4'h4, 2'd2, 32'h0, 32'h0000A578, 4'd7},
    '{1'b1, 4'h6, 2'd1, 32'h0000BEEF, 32'h0, 4'd7},
    '{1'b0, 4'h4, 2'd2, 32'h0, 32'hBEEFA578, 4'd7},
    '{1'b0, 4'h6, 2'd1, 32'h0, 32'h0000BEEF, 4'd7},
    '{1'b0, 4'h5, 2'd0, 32'h0, 32'h000000A5, 4'd7},
    '{1'b1, 4'h4, 2'd2, 32'h12345677, 32'h0, 4'd7},
    '{1'b0, 4'h4, 2'd2, 32'h0, 32'h12345674, 4'd7},
    '{1'b0, 4'h7, 2'd1, 32'h0, 32'h00000012, 4'd7},
    '{1'b1, 4'h7, 2'd1, 32'h0000CDAB, 32'h0, 4'd7},       // R7 word at lane3
    '{1'b0, 4'h4, 2'd2, 32'h0, 32'hAB345674, 4'd7},
    '{1'b1, 4'hC, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd9},       // R9 channel 1
    '{1'b0, 4'h4, 2'd2, 32'h0, 32'hAB345674, 4'd9},
    '{1'b0, 4'hC, 2'd2, 32'h0, 32'hFFFFFFFC, 4'd9},
    '{1'b1, 4'h0, 2'd0, 32'h000000FE, 32'h0, 4'd1},       // R1 mask
    '{1'b0, 4'h0, 2'd0, 32'h0, 32'h00000008, 4'd1},
    '{1'b1, 4'h3, 2'd0, 32'h0000005A, 32'h0, 4'd6},       // R6 timing
    '{1'b1, 4'hB, 2'd0, 32'h000000C3, 32'h0, 4'd6},
    '{1'b0, 4'h3, 2'd0, 32'h0, 32'h0000005A, 4'd6},
    '{1'b0, 4'hB, 2'd0, 32'h0, 32'h000000C3, 4'd6},
    '{1'b1, 4'h1, 2'd0, 32'h000000FF, 32'h0, 4'd6},       // R6 mode shared
    '{1'b0, 4'h9, 2'd0, 32'h0, 32'h00000030, 4'd6},
    '{1'b1, 4'h2, 2'd0, 32'h000000FF, 32'h0, 4'd4},       // R4 rw bits
    '{1'b0, 4'h2, 2'd0, 32'h0, 32'h00000060, 4'd4},
    '{1'b1, 4'h2, 2'd0, 32'h00000000, 32'h0, 4'd4},
    '{1'b0, 4'h2, 2'd0, 32'h0, 32'h00000000, 4'd4},
    '{1'b0, 4'h0, 2'd1, 32'h0, 32'h00000008, 4'd1}        // R1 byte-only offsets
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   bus_wr = 1'b0;
  logic [AW-1:0]          bus_addr = '0;
  logic [1:0]             bus_size = '0;
  logic [31:0]            bus_wdata = '0;
  logic [31:0]            rdata, rdata2;
  logic [NUM_CH-1:0]      eng_done = '0, eng_err = '0, eng_irq = '0;
  logic [NUM_CH-1:0]      start, cancel, dir, load;
  logic [NUM_CH-1:0]      start2, cancel2, dir2, load2;
  logic [NUM_CH*32-1:0]   cur, cur2;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bmdma_regbank #(.NUM_CH(NUM_CH), .TIMING_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_size_i(bus_size), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata),
    .eng_done_i(eng_done), .eng_err_i(eng_err), .eng_irq_i(eng_irq),
    .dma_start_o(start), .dma_cancel_o(cancel), .dma_dir_o(dir),
    .cur_load_o(load), .cur_addr_o(cur)
  );

  bmdma_regbank #(.NUM_CH(NUM_CH), .TIMING_EN(1'b0)) dut2_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_size_i(bus_size), .bus_wdata_i(bus_wdata), .bus_rdata_o(rdata2),
    .eng_done_i(eng_done), .eng_err_i(eng_err), .eng_irq_i(eng_irq),
    .dma_start_o(start2), .dma_cancel_o(cancel2), .dma_dir_o(dir2),
    .cur_load_o(load2), .cur_addr_o(cur2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // write: applied at a falling edge, captured at the next rising edge,
  // returns at the following falling edge where strobes are visible
  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] v);
    bus_addr = a; bus_size = sz;
    #1;
    v = rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: eng_done[0] = 1'b1;
      1: eng_err[0]  = 1'b1;
      default: eng_irq[0] = 1'b1;
    endcase
    @(negedge clk);
    eng_done = '0; eng_err = '0; eng_irq = '0;
  endtask

  task automatic reset_check();
    logic [31:0] v;
    rd(4'h0, 2'd0, v); chk("R10 cmd0", v, 32'h0);
    rd(4'h2, 2'd0, v); chk("R10 stat0", v, 32'h0);
    rd(4'h4, 2'd2, v); chk("R10 desc0", v, 32'h0);
    rd(4'hA, 2'd0, v); chk("R10 stat1", v, 32'h0);
    rd(4'h1, 2'd0, v); chk("R10 mode", v, 32'h0);
    rd(4'hB, 2'd0, v); chk("R10 time1", v, 32'h0);
    chk("R10 strobes", {24'h0, start, cancel, load, dir}, 32'h0);
    chk("R10 cur_addr", cur[31:0] | cur[63:32], 32'h0);
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    // table walk (R1 R4 R6 R7 R9)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].w) begin
        wr(VECS[i].a, VECS[i].sz, VECS[i].d);
      end else begin
        rd(VECS[i].a, VECS[i].sz, v);
        chk($sformatf("R%0d vec%0d", VECS[i].r, i), v, VECS[i].e);
      end
    end

    // R3 start from idle
    wr(4'h0, 2'd0, 32'h01);
    chk("R3 start pulse", {30'h0, start}, 32'h1);
    chk("R2 no cancel on start", {30'h0, cancel}, 32'h0);
    rd(4'h2, 2'd0, v); chk("R3 active set", v, 32'h01);
    @(negedge clk);
    chk("R3 single pulse", {30'h0, start}, 32'h0);
    // R3 no restart while active; R1 direction
    wr(4'h0, 2'd0, 32'h09);
    chk("R3 no restart", {30'h0, start}, 32'h0);
    rd(4'h0, 2'd0, v); chk("R1 cmd 09", v, 32'h09);
    chk("R1 dir out", {30'h0, dir}, 32'h1);
    // R5 engine inputs
    pulse(0);
    rd(4'h2, 2'd0, v); chk("R5 done clears", v, 32'h00);
    pulse(1);
    rd(4'h2, 2'd0, v); chk("R5 err set", v, 32'h02);
    pulse(2);
    rd(4'h2, 2'd0, v); chk("R5 irq set", v, 32'h06);
    // R4 write-1-clear
    wr(4'h2, 2'd0, 32'h02);
    rd(4'h2, 2'd0, v); chk("R4 w1c err", v, 32'h04);
    wr(4'h0, 2'd0, 32'h01);
    rd(4'h2, 2'd0, v); chk("R3 restart idle", v, 32'h05);
    // R4 active is read-only
    wr(4'h2, 2'd0, 32'h00);
    rd(4'h2, 2'd0, v); chk("R4 active ro", v, 32'h05);
    // R5 set wins over clear
    pulse(1);
    @(negedge clk);
    bus_addr = 4'h2; bus_size = 2'd0; bus_wdata = 32'h02; bus_wr = 1'b1; eng_err[0] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; eng_err = '0;
    rd(4'h2, 2'd0, v); chk("R5 set wins", v, 32'h07);
    // R2 cancel
    wr(4'h0, 2'd0, 32'h00);
    chk("R2 cancel pulse", {30'h0, cancel}, 32'h1);
    chk("R2 no start", {30'h0, start}, 32'h0);
    rd(4'h2, 2'd0, v); chk("R2 active cleared", v, 32'h06);
    // R8 pointer load
    wr(4'h4, 2'd0, 32'h10);
    chk("R8 load strobe", {30'h0, load}, 32'h1);
    chk("R8 cur addr", cur[31:0], 32'hAB345610);
    chk("R9 ch1 addr kept", cur[63:32], 32'hFFFFFFFC);
    // R9 channel 1 start
    wr(4'h8, 2'd0, 32'h01);
    chk("R9 ch1 start", {30'h0, start}, 32'h2);
    rd(4'hA, 2'd0, v); chk("R9 ch1 active", v, 32'h01);
    rd(4'h2, 2'd0, v); chk("R9 ch0 untouched", v, 32'h06);
    // R6 disabled feature
    bus_addr = 4'h1; #1; chk("R6 mode off", rdata2, 32'hFF);
    bus_addr = 4'h3; #1; chk("R6 time off", rdata2, 32'hFF);
    bus_addr = 4'hB; #1; chk("R6 time off ch1", rdata2, 32'hFF);

    // R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule